// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This block keeps the machine-level exception state of a small single-issue core and carries out trap entry and trap return. It receives the instruction in the execute stage together with its PC and source operand. It decodes the SYSTEM opcode itself and handles three kinds of work: CSR accesses (swap, set bits, clear bits), environment calls and breakpoints, and the trap-return instruction. Four machine CSRs are implemented: the handler base, the saved PC, the cause, and the trap value.

A synchronous exception reported by the rest of the core (`trap_req` with a cause code and a faulting address) has priority over everything else. In one step the unit saves the PC, records the cause, sets or clears the trap value, and asks fetch to restart at the handler base. A trap-return asks fetch to restart at the saved PC. CSR reads are combinational, so the write-back stage can retire the old value in the same cycle as the instruction. Every state change and every fetch redirect becomes visible one clock later.

Top module: `mtrap_csr_unit`

## Requirements
- R1: A SYSTEM instruction (opcode 0x73) with funct3 001, 010 or 011 that names an implemented CSR asserts `rd_valid` in the same cycle and drives the CSR's current value on `rd_data`. Instructions with any other opcode give `rd_valid` low, cause no redirect and change no CSR. The fields are csr[31:20], rs1[19:15], funct3[14:12], rd[11:7] and opcode[6:0]. The CSR addresses are handler base 0x305, saved PC 0x341, cause 0x342 and trap value 0x343.
- R2: A swap (funct3 001) returns the old value on `rd_data` and installs `rs1_val` in the CSR. A read in the next cycle sees the new value.
- R3: Set-bits (010) stores old|rs1_val and clear-bits (011) stores old&~rs1_val. Both return the old value. When the rs1 field is 0, neither of them writes.
- R4: Bits [1:0] of the handler base always read as zero, whatever value is written, so every redirect to the handler is 4-byte aligned.
- R5: When `trap_req` is high, the next cycle has `redirect_valid` high with `redirect_pc` equal to the handler base. From that cycle on, the saved PC holds `ex_pc` and the cause holds `trap_cause`, zero-extended.
- R6: On trap entry the trap value takes `trap_addr` for causes 0, 1, 4, 5, 6 and 7. For every other cause, and for traps raised inside the unit, it becomes zero.
- R7: 0x00000073 traps with cause 11 and 0x00100073 traps with cause 3. Both save `ex_pc` and redirect to the handler base in the next cycle.
- R8: An access to an unimplemented CSR address, or any other SYSTEM encoding the unit does not support, traps with cause 2. It gives `rd_valid` low and leaves the addressed CSR and the handler base unwritten.
- R9: When `trap_req` and a valid instruction arrive in the same cycle, the instruction is discarded: `rd_valid` is low and its CSR write is lost.
- R10: 0x30200073 gives `redirect_valid` in the next cycle, with `redirect_pc` equal to the saved PC.
- R11: After reset the handler base holds `MTVEC_RST` with bits [1:0] cleared, the other CSRs hold zero, and `redirect_valid` is low. `redirect_valid` is high only in the cycle that follows a trap or a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | An instruction is present in execute |
| instr | input | 32 | The instruction word |
| rs1_val | input | XLEN | Source operand value |
| ex_pc | input | XLEN | PC of the instruction in execute |
| trap_req | input | 1 | Synchronous exception from the core |
| trap_cause | input | CAUSE_W | Cause code of that exception |
| trap_addr | input | XLEN | Faulting address of that exception |
| rd_valid | output | 1 | CSR read result is valid this cycle |
| rd_data | output | XLEN | Old CSR value for the destination register |
| redirect_valid | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | XLEN | Handler base or saved PC |

## Verification
The two results of this unit arrive at different times. `rd_valid` and `rd_data` settle in the same cycle as the instruction, so the bench samples them 1 ns after it drives the inputs, well before the next rising edge. The redirect and the CSR updates come out of the single state register, so the bench samples `redirect_valid` and `redirect_pc` 5 ns after the following rising edge. It then removes the stimulus and confirms any CSR change by reading it back through a later CSR instruction. The bound checker states the same one-cycle relation for trap entry, return, the cause of an environment call and the no-write rule for illegal accesses.

// File: rtl/mtrap_pkg.sv
`timescale 1ns/1ps
package mtrap_pkg;

    localparam int NUM_CSR = 4;

    // Position of each machine CSR in the one-hot select vector
    localparam int IDX_TVEC  = 0;
    localparam int IDX_EPC   = 1;
    localparam int IDX_CAUSE = 2;
    localparam int IDX_TVAL  = 3;

    localparam logic [6:0] OPC_SYSTEM = 7'h73;

    localparam logic [2:0] F3_PRIV = 3'b000;
    localparam logic [2:0] F3_SWAP = 3'b001;
    localparam logic [2:0] F3_SET  = 3'b010;
    localparam logic [2:0] F3_CLR  = 3'b011;

    localparam logic [11:0] IMM_ECALL  = 12'h000;
    localparam logic [11:0] IMM_EBREAK = 12'h001;
    localparam logic [11:0] IMM_MRET   = 12'h302;

    localparam int CAUSE_ILLEGAL = 2;
    localparam int CAUSE_BREAK   = 3;
    localparam int CAUSE_ECALL_M = 11;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SWAP,
        OP_SET,
        OP_CLR,
        OP_ECALL,
        OP_EBREAK,
        OP_MRET,
        OP_ILLEGAL
    } op_e;

    typedef struct packed {
        op_e                op;
        logic [NUM_CSR-1:0] sel;
        logic               wr_en;
    } dec_t;

    function automatic logic [11:0] csr_addr_of(int unsigned idx);
        case (idx)
            0:       return 12'h305;
            1:       return 12'h341;
            2:       return 12'h342;
            default: return 12'h343;
        endcase
    endfunction

    // Causes whose trap value is the faulting address
    function automatic logic cause_keeps_addr(int unsigned c);
        return (c == 0) || (c == 1) || (c == 4) || (c == 5) || (c == 6) || (c == 7);
    endfunction

endpackage

// File: rtl/mtrap_decode.sv
`timescale 1ns/1ps
module mtrap_decode
    import mtrap_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] instr,
    output dec_t        dec
);

    logic [11:0]        f_csr;
    logic [4:0]         f_rs1;
    logic [2:0]         f_fn3;
    logic [4:0]         f_rd;
    logic [6:0]         f_opc;
    logic [NUM_CSR-1:0] hit;

    assign f_csr = instr[31:20];
    assign f_rs1 = instr[19:15];
    assign f_fn3 = instr[14:12];
    assign f_rd  = instr[11:7];
    assign f_opc = instr[6:0];

    for (genvar g = 0; g < NUM_CSR; g++) begin : g_match
        assign hit[g] = (f_csr == csr_addr_of(g));
    end

    always_comb begin
        dec.op    = OP_NONE;
        dec.sel   = '0;
        dec.wr_en = 1'b0;
        if (valid && f_opc == OPC_SYSTEM) begin
            case (f_fn3)
                F3_PRIV: begin
                    if (f_rs1 != 5'd0 || f_rd != 5'd0) begin
                        dec.op = OP_ILLEGAL;
                    end else if (f_csr == IMM_ECALL) begin
                        dec.op = OP_ECALL;
                    end else if (f_csr == IMM_EBREAK) begin
                        dec.op = OP_EBREAK;
                    end else if (f_csr == IMM_MRET) begin
                        dec.op = OP_MRET;
                    end else begin
                        dec.op = OP_ILLEGAL;
                    end
                end
                F3_SWAP, F3_SET, F3_CLR: begin
                    if (hit == '0) begin
                        dec.op = OP_ILLEGAL;
                    end else begin
                        dec.op    = (f_fn3 == F3_SWAP) ? OP_SWAP :
                                    (f_fn3 == F3_SET)  ? OP_SET  : OP_CLR;
                        dec.sel   = hit;
                        dec.wr_en = (f_fn3 == F3_SWAP) || (f_rs1 != 5'd0);
                    end
                end
                default: dec.op = OP_ILLEGAL;
            endcase
        end
    end

endmodule

// File: rtl/mtrap_tval_sel.sv
`timescale 1ns/1ps
module mtrap_tval_sel
    import mtrap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    addr,
    output logic [XLEN-1:0]    tval
);

    localparam int NCODES = 1 << CAUSE_W;

    logic [NCODES-1:0] keep;

    for (genvar g = 0; g < NCODES; g++) begin : g_keep
        assign keep[g] = cause_keeps_addr(g);
    end

    assign tval = keep[cause] ? addr : '0;

endmodule

// File: rtl/mtrap_csr_file.sv
`timescale 1ns/1ps
module mtrap_csr_file
    import mtrap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CAUSE_W   = 4,
    parameter logic [XLEN-1:0] MTVEC_RST = XLEN'('h100)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  dec_t               dec,
    input  logic [XLEN-1:0]    rs1_val,
    input  logic [XLEN-1:0]    ex_pc,
    input  logic               trap_req,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_tval,
    output logic               rd_valid,
    output logic [XLEN-1:0]    rd_data,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [XLEN-1:0]    mtvec_o,
    output logic [XLEN-1:0]    mepc_o,
    output logic [XLEN-1:0]    mcause_o
);

    typedef struct packed {
        logic [XLEN-1:0] mtvec;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mtval;
        logic            redir_v;
        logic [XLEN-1:0] redir_pc;
    } state_t;

    state_t          st_q, st_d;
    logic [XLEN-1:0] csr_view [NUM_CSR];
    logic [XLEN-1:0] old_val;
    logic [XLEN-1:0] new_val;
    logic            is_access;
    logic            enter;
    logic [XLEN-1:0] cause_n;
    logic [XLEN-1:0] tval_n;

    always_comb begin
        csr_view[IDX_TVEC]  = st_q.mtvec;
        csr_view[IDX_EPC]   = st_q.mepc;
        csr_view[IDX_CAUSE] = st_q.mcause;
        csr_view[IDX_TVAL]  = st_q.mtval;
    end

    // Old value of the addressed CSR
    always_comb begin
        old_val = '0;
        for (int i = 0; i < NUM_CSR; i++) begin
            if (dec.sel[i]) old_val = old_val | csr_view[i];
        end
    end

    assign is_access = (dec.op == OP_SWAP) || (dec.op == OP_SET) || (dec.op == OP_CLR);
    assign rd_valid  = is_access && !trap_req;
    assign rd_data   = rd_valid ? old_val : '0;

    always_comb begin
        case (dec.op)
            OP_SET:  new_val = old_val | rs1_val;
            OP_CLR:  new_val = old_val & ~rs1_val;
            default: new_val = rs1_val;
        endcase
    end

    always_comb begin
        st_d         = st_q;
        st_d.redir_v = 1'b0;
        enter        = 1'b0;
        cause_n      = '0;
        tval_n       = '0;
        if (trap_req) begin
            enter   = 1'b1;
            cause_n = XLEN'(trap_cause);
            tval_n  = trap_tval;
        end else begin
            case (dec.op)
                OP_ILLEGAL: begin
                    enter   = 1'b1;
                    cause_n = XLEN'(CAUSE_ILLEGAL);
                end
                OP_ECALL: begin
                    enter   = 1'b1;
                    cause_n = XLEN'(CAUSE_ECALL_M);
                end
                OP_EBREAK: begin
                    enter   = 1'b1;
                    cause_n = XLEN'(CAUSE_BREAK);
                end
                OP_MRET: begin
                    st_d.redir_v  = 1'b1;
                    st_d.redir_pc = st_q.mepc;
                end
                OP_SWAP, OP_SET, OP_CLR: begin
                    if (dec.wr_en) begin
                        if (dec.sel[IDX_TVEC])  st_d.mtvec  = {new_val[XLEN-1:2], 2'b00};
                        if (dec.sel[IDX_EPC])   st_d.mepc   = new_val;
                        if (dec.sel[IDX_CAUSE]) st_d.mcause = new_val;
                        if (dec.sel[IDX_TVAL])  st_d.mtval  = new_val;
                    end
                end
                default: ;
            endcase
        end
        if (enter) begin
            st_d.mepc     = ex_pc;
            st_d.mcause   = cause_n;
            st_d.mtval    = tval_n;
            st_d.redir_v  = 1'b1;
            st_d.redir_pc = st_q.mtvec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mtvec <= {MTVEC_RST[XLEN-1:2], 2'b00};
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid = st_q.redir_v;
    assign redirect_pc    = st_q.redir_pc;
    assign mtvec_o        = st_q.mtvec;
    assign mepc_o         = st_q.mepc;
    assign mcause_o       = st_q.mcause;

endmodule

// File: rtl/mtrap_csr_unit.sv
`timescale 1ns/1ps
module mtrap_csr_unit
    import mtrap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CAUSE_W   = 4,
    parameter logic [XLEN-1:0] MTVEC_RST = XLEN'('h100)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [31:0]        instr,
    input  logic [XLEN-1:0]    rs1_val,
    input  logic [XLEN-1:0]    ex_pc,
    input  logic               trap_req,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_addr,
    output logic               rd_valid,
    output logic [XLEN-1:0]    rd_data,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc
);

    dec_t            dec;
    logic [XLEN-1:0] tval_sel;
    logic [XLEN-1:0] mtvec_cur;
    logic [XLEN-1:0] mepc_cur;
    logic [XLEN-1:0] mcause_cur;
    logic            dec_illegal;
    logic            dec_mret;
    logic            dec_ecall;

    mtrap_decode u_decode (
        .valid (instr_valid),
        .instr (instr),
        .dec   (dec)
    );

    mtrap_tval_sel #(
        .XLEN    (XLEN),
        .CAUSE_W (CAUSE_W)
    ) u_tval (
        .cause (trap_cause),
        .addr  (trap_addr),
        .tval  (tval_sel)
    );

    mtrap_csr_file #(
        .XLEN      (XLEN),
        .CAUSE_W   (CAUSE_W),
        .MTVEC_RST (MTVEC_RST)
    ) u_file (
        .clk            (clk),
        .rst_n          (rst_n),
        .dec            (dec),
        .rs1_val        (rs1_val),
        .ex_pc          (ex_pc),
        .trap_req       (trap_req),
        .trap_cause     (trap_cause),
        .trap_tval      (tval_sel),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .mtvec_o        (mtvec_cur),
        .mepc_o         (mepc_cur),
        .mcause_o       (mcause_cur)
    );

    assign dec_illegal = (dec.op == OP_ILLEGAL);
    assign dec_mret    = (dec.op == OP_MRET);
    assign dec_ecall   = (dec.op == OP_ECALL);

endmodule

// File: rtl/mtrap_csr_chk.sv
`timescale 1ns/1ps
module mtrap_csr_chk #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               instr_valid,
    input logic               trap_req,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic [XLEN-1:0]    ex_pc,
    input logic               is_illegal,
    input logic               is_mret,
    input logic               is_ecall,
    input logic               redirect_valid,
    input logic [XLEN-1:0]    redirect_pc,
    input logic [XLEN-1:0]    mtvec_cur,
    input logic [XLEN-1:0]    mepc_cur,
    input logic [XLEN-1:0]    mcause_cur
);

    // R4
    handler_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mtvec_cur[1:0] == 2'b00);

    // R5
    trap_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> redirect_valid && redirect_pc == $past(mtvec_cur));

    // R5
    trap_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> mepc_cur == $past(ex_pc) && mcause_cur == XLEN'($past(trap_cause)));

    // R9
    trap_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> $stable(mtvec_cur));

    // R8
    illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_illegal && !trap_req) |=> $stable(mtvec_cur) && mcause_cur == XLEN'(2));

    // R7
    ecall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ecall && !trap_req) |=> mcause_cur == XLEN'(11));

    // R10
    return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mret && !trap_req) |=> redirect_valid && redirect_pc == $past(mepc_cur));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid && !trap_req) |=> !redirect_valid);

endmodule

bind mtrap_csr_unit mtrap_csr_chk #(
    .XLEN    (XLEN),
    .CAUSE_W (CAUSE_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_valid    (instr_valid),
    .trap_req       (trap_req),
    .trap_cause     (trap_cause),
    .ex_pc          (ex_pc),
    .is_illegal     (dec_illegal),
    .is_mret        (dec_mret),
    .is_ecall       (dec_ecall),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .mtvec_cur      (mtvec_cur),
    .mepc_cur       (mepc_cur),
    .mcause_cur     (mcause_cur)
);

// File: tb/mtrap_csr_unit_bench.sv
`timescale 1ns/1ps
module mtrap_csr_unit_bench;

    localparam int XLEN    = 32;
    localparam int CAUSE_W = 4;

    logic               clk;
    logic               rst_n;
    logic               instr_valid;
    logic [31:0]        instr;
    logic [XLEN-1:0]    rs1_val;
    logic [XLEN-1:0]    ex_pc;
    logic               trap_req;
    logic [CAUSE_W-1:0] trap_cause;
    logic [XLEN-1:0]    trap_addr;
    logic               rd_valid;
    logic [XLEN-1:0]    rd_data;
    logic               redirect_valid;
    logic [XLEN-1:0]    redirect_pc;

    int n_checks = 0;
    int n_fails  = 0;

    mtrap_csr_unit #(
        .XLEN      (XLEN),
        .CAUSE_W   (CAUSE_W),
        .MTVEC_RST (32'h100)
    ) u_mtrap_csr_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .instr_valid    (instr_valid),
        .instr          (instr),
        .rs1_val        (rs1_val),
        .ex_pc          (ex_pc),
        .trap_req       (trap_req),
        .trap_cause     (trap_cause),
        .trap_addr      (trap_addr),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [31:0] enc(logic [11:0] a, logic [4:0] r1, logic [2:0] f3, logic [4:0] rd);
        return {a, r1, f3, rd, 7'h73};
    endfunction

    function automatic logic [31:0] rdcsr(logic [11:0] a);
        return {a, 5'd0, 3'b010, 5'd1, 7'h73};
    endfunction

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] rs1;
        logic [31:0] pc;
        logic        erv;
        logic [31:0] erd;
        logic        eredir;
        logic [31:0] epc;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VEC [NVEC] = '{
        '{rdcsr(12'h305), 32'hFFFF_FFFF, 32'h0,   1'b1, 32'h100,  1'b0, 32'h0,    4'd11}, // R11 R3
        '{enc(12'h305, 5'd2, 3'b001, 5'd1), 32'h2003, 32'h0, 1'b1, 32'h100, 1'b0, 32'h0, 4'd2}, // R2
        '{rdcsr(12'h305), 32'h0,  32'h0,   1'b1, 32'h2000, 1'b0, 32'h0,    4'd4},  // R4
        '{enc(12'h341, 5'd5, 3'b010, 5'd3), 32'h13, 32'h0, 1'b1, 32'h0, 1'b0, 32'h0, 4'd3}, // R3
        '{enc(12'h341, 5'd5, 3'b011, 5'd3), 32'h3,  32'h0, 1'b1, 32'h13, 1'b0, 32'h0, 4'd3}, // R3
        '{rdcsr(12'h341), 32'h0,  32'h0,   1'b1, 32'h10,   1'b0, 32'h0,    4'd3},  // R3
        '{32'h3020_0073,  32'h0,  32'h0,   1'b0, 32'h0,    1'b1, 32'h10,   4'd10}, // R10
        '{32'h0000_0073,  32'h0,  32'h400, 1'b0, 32'h0,    1'b1, 32'h2000, 4'd7},  // R7
        '{rdcsr(12'h342), 32'h0,  32'h0,   1'b1, 32'd11,   1'b0, 32'h0,    4'd7},  // R7
        '{rdcsr(12'h341), 32'h0,  32'h0,   1'b1, 32'h400,  1'b0, 32'h0,    4'd5},  // R5
        '{rdcsr(12'h343), 32'h0,  32'h0,   1'b1, 32'h0,    1'b0, 32'h0,    4'd6},  // R6
        '{enc(12'h7C0, 5'd2, 3'b001, 5'd1), 32'hDEAD, 32'h500, 1'b0, 32'h0, 1'b1, 32'h2000, 4'd8}, // R8
        '{rdcsr(12'h342), 32'h0,  32'h0,   1'b1, 32'd2,    1'b0, 32'h0,    4'd8},  // R8
        '{rdcsr(12'h305), 32'h0,  32'h0,   1'b1, 32'h2000, 1'b0, 32'h0,    4'd8},  // R8
        '{32'h0010_0073,  32'h0,  32'h600, 1'b0, 32'h0,    1'b1, 32'h2000, 4'd7},  // R7
        '{rdcsr(12'h342), 32'h0,  32'h0,   1'b1, 32'd3,    1'b0, 32'h0,    4'd7},  // R7
        '{32'h1050_0073,  32'h0,  32'h700, 1'b0, 32'h0,    1'b1, 32'h2000, 4'd8},  // R8
        '{rdcsr(12'h342), 32'h0,  32'h0,   1'b1, 32'd2,    1'b0, 32'h0,    4'd8},  // R8
        '{32'h0000_0013,  32'h55, 32'h800, 1'b0, 32'h0,    1'b0, 32'h0,    4'd1},  // R1
        '{rdcsr(12'h341), 32'h0,  32'h0,   1'b1, 32'h700,  1'b0, 32'h0,    4'd1}   // R1
    };

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic step(input logic [31:0] ins, input logic [31:0] rs1, input logic [31:0] pc,
                        input logic tr, input logic [3:0] tc, input logic [31:0] ta,
                        input logic erv, input logic [31:0] erd,
                        input logic eredir, input logic [31:0] epc, input string tag);
        instr_valid = 1'b1;
        instr       = ins;
        rs1_val     = rs1;
        ex_pc       = pc;
        trap_req    = tr;
        trap_cause  = tc;
        trap_addr   = ta;
        #1;
        check({tag, " read"}, {31'd0, rd_valid, rd_data}, {31'd0, erv, erv ? erd : 32'd0});
        @(posedge clk);
        #5;
        instr_valid = 1'b0;
        trap_req    = 1'b0;
        check({tag, " redirect"}, {31'd0, redirect_valid, redirect_valid ? redirect_pc : 32'd0},
              {31'd0, eredir, eredir ? epc : 32'd0});
        @(negedge clk);
    endtask

    task automatic rd_expect(input logic [11:0] a, input logic [31:0] exp, input string tag);
        step(rdcsr(a), 32'h0, 32'h0, 1'b0, 4'd0, 32'h0, 1'b1, exp, 1'b0, 32'h0, tag);
    endtask

    initial begin
        #(20 * 20000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        instr_valid = 1'b0;
        instr       = '0;
        rs1_val     = '0;
        ex_pc       = '0;
        trap_req    = 1'b0;
        trap_cause  = '0;
        trap_addr   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11 reset state at the ports
        check("R11 reset redirect", {63'd0, redirect_valid}, 64'd0);
        check("R11 reset read", {63'd0, rd_valid}, 64'd0);
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].ins, VEC[i].rs1, VEC[i].pc, 1'b0, 4'd0, 32'h0,
                 VEC[i].erv, VEC[i].erd, VEC[i].eredir, VEC[i].epc,
                 $sformatf("R%0d vec%0d", VEC[i].req, i));
        end

        // R9 R5 trap with a simultaneous swap to the handler base
        step(enc(12'h305, 5'd2, 3'b001, 5'd1), 32'h4444, 32'h800, 1'b1, 4'd5, 32'hABC0,
             1'b0, 32'h0, 1'b1, 32'h2000, "R9 trap wins");
        rd_expect(12'h305, 32'h2000, "R9 write discarded");
        rd_expect(12'h342, 32'd5,    "R5 cause saved");
        rd_expect(12'h341, 32'h800,  "R5 pc saved");
        rd_expect(12'h343, 32'hABC0, "R6 address kept");

        // R6 page fault clears the trap value
        step(32'h0, 32'h0, 32'h900, 1'b1, 4'd13, 32'h1234,
             1'b0, 32'h0, 1'b1, 32'h2000, "R5 page fault");
        rd_expect(12'h343, 32'h0, "R6 page fault tval");
        step(32'h0, 32'h0, 32'hA00, 1'b1, 4'd0, 32'h77,
             1'b0, 32'h0, 1'b1, 32'h2000, "R5 misaligned fetch");
        rd_expect(12'h343, 32'h77, "R6 misaligned tval");

        // R10 return after an external trap
        step(32'h3020_0073, 32'h0, 32'h0, 1'b0, 4'd0, 32'h0,
             1'b0, 32'h0, 1'b1, 32'hA00, "R10 return");

        // R4 low bits of the handler base stay clear
        step(enc(12'h305, 5'd2, 3'b001, 5'd1), 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd0, 32'h0,
             1'b1, 32'h2000, 1'b0, 32'h0, "R4 swap");
        rd_expect(12'h305, 32'hFFFF_FFFC, "R4 aligned read");
        step(32'h0, 32'h0, 32'hB00, 1'b1, 4'd2, 32'h0,
             1'b0, 32'h0, 1'b1, 32'hFFFF_FFFC, "R4 aligned redirect");

        // R8 immediate-form CSR op is unsupported
        step(enc(12'h341, 5'd3, 3'b101, 5'd1), 32'h0, 32'hC00, 1'b0, 4'd0, 32'h0,
             1'b0, 32'h0, 1'b1, 32'hFFFF_FFFC, "R8 immediate form");
        rd_expect(12'h342, 32'd2, "R8 immediate cause");

        // R11 idle cycle keeps the redirect low
        @(posedge clk);
        #5;
        check("R11 idle redirect", {63'd0, redirect_valid}, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule